// File: doc/BRIEF.md
# SD Card Block Data Phase Engine

This engine carries out the data phase of SD card block transfers in SPI mode, once a read or write command has already been accepted by the card. It sits between a byte-wide SPI exchange port (one byte out, one byte in per exchange) and a pair of byte streams with valid/ready handshakes: one stream delivers read payload to memory or a DMA engine, the other takes write payload from them. The command layer starts the engine with a direction, a single/multi-block choice and a block count, and gets back a one-cycle done pulse together with a two-bit result code.

For reads, the engine polls the card with 0xFF until the data start token appears, passes the 512 payload bytes downstream, then clocks out and throws away the two CRC bytes. For writes, it sends a gap byte, the start token, the payload and a dummy CRC of 0xFFFF. It then reads the data-response byte and waits out the card's programming busy period. Multi-block writes use their own per-block token and finish with a stop token and one more busy wait. Each transfer ends with one trailing 0xFF byte sent while the engine asks the chip-select owner to release the card. Both the token wait and the busy wait have byte-count limits. Chip select itself and command issue are handled elsewhere.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset, and whenever no transfer is active, `xfer_busy`, `card_sel`, `spi_start`, `rd_valid`, `wr_ready` and `xfer_done` are all low.
- R2: On a read block, every polling byte sent is 0xFF. Polling continues until a received byte equals 0xFE, and any other value, including 0xFC, keeps it polling. The next 512 received bytes go out on `rd_data` in order. Two further 0xFF exchanges then take the CRC, which never reaches the stream. A successful transfer ends with `xfer_err` = 0.
- R3: If TOK_WAIT polling bytes in a row bring no 0xFE, the read ends with `xfer_err` = 1 and goes directly to the trailing byte.
- R4: A read of N blocks (`xfer_nblk` = N) repeats token wait, payload and CRC N times. Each block has its own token wait.
- R5: A write block sends 0xFF (gap), the start token, 512 payload bytes taken in order from `wr_data`, then 0xFF, 0xFF as CRC. The start token is 0xFE when `xfer_multi` = 0.
- R6: With `xfer_multi` = 1 the start token of every block is 0xFC. After the last block's busy wait, 0xFD is sent, followed by another busy wait.
- R7: After each write block's CRC, one 0xFF is sent and the received byte is ANDed with 0x1F. If the result is 0x05 the busy wait follows. Any other result ends the transfer with `xfer_err` = 2: no busy poll, no further blocks and no stop token are sent.
- R8: The busy wait sends 0xFF while the received byte is 0x00 and ends on the first nonzero byte. If BUSY_WAIT zero bytes arrive in a row, the transfer ends with `xfer_err` = 3.
- R9: Every transfer ends with exactly one 0xFF exchange during which `card_sel` is low. `card_sel` is high for every other byte of the transfer. A one-cycle `xfer_done` pulse follows that exchange.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_data` stays stable and no SPI exchange starts. A payload byte is sent only in a cycle where both `wr_valid` and `wr_ready` are high.
- R11: At most one SPI exchange is outstanding: `spi_start` is raised only after the previous exchange's `spi_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_go | input | 1 | Start pulse, sampled while idle |
| xfer_wr | input | 1 | 1 = write, 0 = read |
| xfer_multi | input | 1 | Multi-block write tokens and stop token |
| xfer_nblk | input | NB_W | Block count (0 is taken as 1) |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_err | output | 2 | 0 ok, 1 token timeout, 2 write rejected, 3 busy timeout |
| card_sel | output | 1 | Request to keep the card selected |
| spi_start | output | 1 | Begin one byte exchange |
| spi_tx | output | 8 | Byte to send, valid with spi_start |
| spi_done | input | 1 | Exchange finished |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte available |
| rd_ready | input | 1 | Consumer accepts read byte |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Producer offers write byte |
| wr_ready | output | 1 | Engine accepts write byte |

## Verification
A wrong sequencer state shows up at the SPI port on the very next exchange. Examples are a token byte where a gap belongs, an extra busy poll, or a missing stop token. The bench compares every outgoing byte, along with its `card_sel` value, against an expected sequence, so such a fault surfaces within one byte time. A miscounted payload counter instead shows as a stream byte out of order, or as CRC bytes leaking into the stream, at the 512th byte boundary. A wrong wait counter or response mask shows as the wrong result code when the done pulse arrives.

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer #(
  parameter int BLK_BYTES = 512,
  parameter int NB_W      = 16,
  parameter int TOK_WAIT  = 4096,
  parameter int BUSY_WAIT = 65536
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_go,
  input  logic            xfer_wr,
  input  logic            xfer_multi,
  input  logic [NB_W-1:0] xfer_nblk,
  output logic            xfer_busy,
  output logic            xfer_done,
  output logic [1:0]      xfer_err,
  output logic            card_sel,
  output logic            spi_start,
  output logic [7:0]      spi_tx,
  input  logic            spi_done,
  input  logic [7:0]      spi_rx,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  input  logic [7:0]      wr_data,
  input  logic            wr_valid,
  output logic            wr_ready
);
  localparam int BW   = $clog2(BLK_BYTES);
  localparam int WMAX = (TOK_WAIT > BUSY_WAIT) ? TOK_WAIT : BUSY_WAIT;
  localparam int TW   = $clog2(WMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RTOK, S_RDAT, S_RCRC, S_WGAP, S_WTOK,
    S_WDAT, S_WCRC, S_WRSP, S_WBSY, S_WSTP, S_TRL
  } st_t;

  st_t             st;
  logic            pend, rvalid, multi_q, stopping;
  logic [7:0]      rbuf;
  logic [BW-1:0]   bcnt;
  logic [TW-1:0]   wcnt;
  logic [NB_W-1:0] left;

  wire last_byte = bcnt == BW'(BLK_BYTES - 1);
  wire last_blk  = left == NB_W'(1);
  wire rsp_ok    = (spi_rx & 8'h1F) == 8'h05;
  wire tok_exp   = wcnt == TW'(TOK_WAIT - 1);
  wire bsy_exp   = wcnt == TW'(BUSY_WAIT - 1);

  assign xfer_busy = st != S_IDLE;
  assign card_sel  = st != S_IDLE && st != S_TRL;
  assign wr_ready  = st == S_WDAT && !pend;
  assign rd_valid  = rvalid;
  assign rd_data   = rbuf;
  assign spi_start = !pend && st != S_IDLE &&
                     (st == S_RDAT ? !rvalid : st == S_WDAT ? wr_valid : 1'b1);

  always_comb begin
    case (st)
      S_WTOK:  spi_tx = multi_q ? 8'hFC : 8'hFE;
      S_WDAT:  spi_tx = wr_data;
      S_WSTP:  spi_tx = 8'hFD;
      default: spi_tx = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b0; rvalid <= 1'b0; multi_q <= 1'b0;
      stopping <= 1'b0; rbuf <= 8'h00; bcnt <= '0; wcnt <= '0;
      left <= '0; xfer_done <= 1'b0; xfer_err <= 2'd0;
    end else begin
      xfer_done <= 1'b0;
      if (spi_done)  pend <= 1'b0;
      if (spi_start) pend <= 1'b1;
      case (st)
        S_IDLE: if (xfer_go) begin
          multi_q  <= xfer_multi;
          left     <= (xfer_nblk == '0) ? NB_W'(1) : xfer_nblk;
          wcnt     <= '0;
          bcnt     <= '0;
          stopping <= 1'b0;
          xfer_err <= 2'd0;
          st       <= xfer_wr ? S_WGAP : S_RTOK;
        end
        S_RTOK: if (spi_done) begin
          if (spi_rx == 8'hFE) begin
            st <= S_RDAT; bcnt <= '0;
          end else if (tok_exp) begin
            xfer_err <= 2'd1; st <= S_TRL;
          end else wcnt <= wcnt + 1'b1;
        end
        S_RDAT: if (spi_done) begin
          rbuf <= spi_rx; rvalid <= 1'b1;
        end else if (rvalid && rd_ready) begin
          rvalid <= 1'b0;
          if (last_byte) begin
            st <= S_RCRC; bcnt <= '0;
          end else bcnt <= bcnt + 1'b1;
        end
        S_RCRC: if (spi_done) begin
          if (bcnt[0]) begin
            bcnt <= '0;
            if (last_blk) st <= S_TRL;
            else begin
              left <= left - 1'b1; wcnt <= '0; st <= S_RTOK;
            end
          end else bcnt <= BW'(1);
        end
        S_WGAP: if (spi_done) st <= S_WTOK;
        S_WTOK: if (spi_done) begin
          st <= S_WDAT; bcnt <= '0;
        end
        S_WDAT: if (spi_done) begin
          if (last_byte) begin
            st <= S_WCRC; bcnt <= '0;
          end else bcnt <= bcnt + 1'b1;
        end
        S_WCRC: if (spi_done) begin
          if (bcnt[0]) begin
            bcnt <= '0; st <= S_WRSP;
          end else bcnt <= BW'(1);
        end
        S_WRSP: if (spi_done) begin
          if (rsp_ok) begin
            wcnt <= '0; st <= S_WBSY;
          end else begin
            xfer_err <= 2'd2; st <= S_TRL;
          end
        end
        S_WBSY: if (spi_done) begin
          if (spi_rx != 8'h00) begin
            if (stopping || (last_blk && !multi_q)) st <= S_TRL;
            else if (last_blk) st <= S_WSTP;
            else begin
              left <= left - 1'b1; st <= S_WGAP;
            end
          end else if (bsy_exp) begin
            xfer_err <= 2'd3; st <= S_TRL;
          end else wcnt <= wcnt + 1'b1;
        end
        S_WSTP: if (spi_done) begin
          stopping <= 1'b1; wcnt <= '0; st <= S_WBSY;
        end
        S_TRL: if (spi_done) begin
          xfer_done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_blk_xfer_chk.sv
module sd_blk_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_busy,
  input logic       xfer_done,
  input logic       card_sel,
  input logic       spi_start,
  input logic       spi_done,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       wr_ready
);
  logic [1:0] outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 2'd0;
    else if (spi_start && !spi_done) outst <= outst + 2'd1;
    else if (spi_done && !spi_start) outst <= outst - 2'd1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> !spi_start && !card_sel && !rd_valid && !wr_ready); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R10
  AST_RD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_start); // R10
  AST_START_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> outst == 2'd0); // R11
  AST_DONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_done |-> outst == 2'd1); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R9
  AST_DESEL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_sel) |-> xfer_busy); // R9
endmodule

bind sd_blk_xfer sd_blk_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
  .card_sel(card_sel), .spi_start(spi_start), .spi_done(spi_done),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .wr_ready(wr_ready)
);

// File: tb/tb_sd_blk_xfer.sv
module tb_sd_blk_xfer;
  localparam int NBYTES = 512;
  localparam int TOKW   = 16;
  localparam int BSYW   = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xfer_go = 0, xfer_wr = 0, xfer_multi = 0;
  logic [15:0] xfer_nblk = 16'd1;
  logic xfer_busy, xfer_done, card_sel, spi_start, rd_valid, wr_ready;
  logic [1:0] xfer_err;
  logic [7:0] spi_tx, rd_data;
  logic spi_done = 0, rd_ready = 0, wr_valid = 0;
  logic [7:0] spi_rx = 8'h00, wr_data = 8'h00;

  always #10 clk = ~clk;

  sd_blk_xfer #(.BLK_BYTES(NBYTES), .NB_W(16), .TOK_WAIT(TOKW), .BUSY_WAIT(BSYW)) dut (
    .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .xfer_wr(xfer_wr),
    .xfer_multi(xfer_multi), .xfer_nblk(xfer_nblk), .xfer_busy(xfer_busy),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .card_sel(card_sel),
    .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready));

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  logic [8:0] exp_tx[$];
  logic [7:0] exp_rd[$], src[$], script[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int blk, input int i);
    return 8'((i * 7) + (blk * 29) + 8'h3C);
  endfunction

  task automatic etx(input logic sel, input logic [7:0] b, input int n);
    for (int k = 0; k < n; k++) exp_tx.push_back({sel, b});
  endtask
  task automatic rx(input logic [7:0] b, input int n);
    for (int k = 0; k < n; k++) script.push_back(b);
  endtask

  // stream driver and read-side monitor
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = lfsr[0] | lfsr[5];
    if (rd_valid && rd_ready) begin
      if (exp_rd.size() == 0) chk(0, cur_req, "unexpected stream byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rd.pop_front();
        chk(rd_data == e, cur_req, "read stream byte", rd_data, e);
      end
    end
    wr_valid = (src.size() > 0) && (lfsr[1] | lfsr[7]);
    wr_data  = (src.size() > 0) ? src[0] : 8'h00;
    if (wr_valid && wr_ready) void'(src.pop_front());
  end

  // card model and SPI-side monitor
  int lat = 0;
  logic [7:0] pending = 8'hFF;
  initial forever begin
    @(negedge clk);
    #1;
    spi_done = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin spi_done = 1'b1; spi_rx = pending; end
    end
    if (spi_start) begin
      if (exp_tx.size() == 0) chk(0, cur_req, "unexpected spi byte", {card_sel, spi_tx}, 0);
      else begin
        logic [8:0] e;
        e = exp_tx.pop_front();
        chk({card_sel, spi_tx} == e, cur_req, "spi {sel,byte}", {card_sel, spi_tx}, e);
      end
      pending = (script.size() > 0) ? script.pop_front() : 8'hFF;
      lat = 3;
    end
  end

  task automatic run(input bit wr, input bit multi, input int nblk, input logic [1:0] eerr);
    int guard;
    @(negedge clk);
    xfer_wr = wr; xfer_multi = multi; xfer_nblk = 16'(nblk); xfer_go = 1'b1;
    @(negedge clk);
    xfer_go = 1'b0;
    guard = 0;
    while (!xfer_done && guard < 40000) begin @(negedge clk); guard++; end
    chk(xfer_done, cur_req, "done pulse seen", xfer_done, 1);
    chk(xfer_err == eerr, cur_req, "result code", xfer_err, eerr);
    repeat (3) @(negedge clk);
    chk(exp_tx.size() == 0, cur_req, "spi bytes left unsent", exp_tx.size(), 0);
    chk(exp_rd.size() == 0, cur_req, "stream bytes left undelivered", exp_rd.size(), 0);
    chk(src.size() == 0, cur_req, "write bytes left unconsumed", src.size(), 0);
    chk(!xfer_busy && !card_sel, cur_req, "idle after done", {xfer_busy, card_sel}, 0);
    script.delete();
  endtask

  task automatic wr_block(input int b, input logic [7:0] tok);
    etx(1, 8'hFF, 1); etx(1, tok, 1);
    for (int i = 0; i < NBYTES; i++) begin src.push_back(pat(b, i)); etx(1, pat(b, i), 1); end
    etx(1, 8'hFF, 3);  // CRC x2, response poll
    rx(8'hFF, NBYTES + 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!xfer_busy && !card_sel && !spi_start && !rd_valid && !wr_ready && !xfer_done,
        "R1", "outputs quiet in reset", {xfer_busy, card_sel, spi_start}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!xfer_busy && !card_sel && !spi_start && !rd_valid && !wr_ready,
        "R1", "outputs quiet after reset", {xfer_busy, card_sel, spi_start}, 0);

    // R2 R9 R10: single read, 0xFC ignored while polling, CRC discarded
    cur_req = "R2";
    rx(8'hFF, 1); rx(8'hFC, 1); rx(8'hFE, 1);
    for (int i = 0; i < NBYTES; i++) begin rx(pat(0, i), 1); exp_rd.push_back(pat(0, i)); end
    rx(8'h12, 1); rx(8'h34, 1);
    etx(1, 8'hFF, 3 + NBYTES + 2); etx(0, 8'hFF, 1);
    run(0, 0, 1, 2'd0);

    // R4: two-block read, each block has its own token wait
    cur_req = "R4";
    rx(8'hFE, 1);
    for (int i = 0; i < NBYTES; i++) begin rx(pat(1, i), 1); exp_rd.push_back(pat(1, i)); end
    rx(8'hAA, 1); rx(8'h55, 1); rx(8'hFF, 2); rx(8'hFE, 1);
    for (int i = 0; i < NBYTES; i++) begin rx(pat(2, i), 1); exp_rd.push_back(pat(2, i)); end
    rx(8'hFE, 2);
    etx(1, 8'hFF, 1 + NBYTES + 2 + 3 + NBYTES + 2); etx(0, 8'hFF, 1);
    run(0, 1, 2, 2'd0);

    // R3: token timeout after TOKW polls
    cur_req = "R3";
    etx(1, 8'hFF, TOKW); etx(0, 8'hFF, 1);
    run(0, 0, 1, 2'd1);

    // R5 R7 R8: single write, response masked, busy for three bytes
    cur_req = "R5";
    wr_block(3, 8'hFE);
    rx(8'hE5, 1); rx(8'h00, 3); rx(8'hFF, 1);
    etx(1, 8'hFF, 4); etx(0, 8'hFF, 1);
    run(1, 0, 1, 2'd0);

    // R7: rejected write ends at once, no busy poll
    cur_req = "R7";
    wr_block(4, 8'hFE);
    rx(8'h0B, 1); rx(8'h00, 4);
    etx(0, 8'hFF, 1);
    run(1, 0, 1, 2'd2);

    // R7: rejection in a multi-block write sends no further block and no stop token
    cur_req = "R7";
    wr_block(5, 8'hFC);
    rx(8'h0D, 1); rx(8'h00, 4);
    etx(0, 8'hFF, 1);
    run(1, 1, 2, 2'd2);

    // R6: two-block multi write, 0xFC tokens, 0xFD stop, final busy wait
    cur_req = "R6";
    wr_block(6, 8'hFC);
    rx(8'h05, 1); rx(8'h00, 1); rx(8'hFF, 1);
    etx(1, 8'hFF, 2);
    wr_block(7, 8'hFC);
    rx(8'h05, 1); rx(8'h00, 1); rx(8'hFF, 1);
    etx(1, 8'hFF, 2);
    rx(8'hFF, 1); etx(1, 8'hFD, 1);
    rx(8'h00, 2); rx(8'hFF, 1); etx(1, 8'hFF, 3);
    etx(0, 8'hFF, 1);
    run(1, 1, 2, 2'd0);

    // R8: busy timeout after BSYW zero bytes
    cur_req = "R8";
    wr_block(8, 8'hFE);
    rx(8'h05, 1); rx(8'h00, BSYW + 1);
    etx(1, 8'hFF, BSYW); etx(0, 8'hFF, 1);
    run(1, 0, 1, 2'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL %s watchdog expired: actual 1 expected 0", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule